// File: doc/BRIEF.md
# Two-Domain Clock-Generator Reset Sequencer

This block brings a clock generator and the logic it clocks out of reset in a fixed order. At power-up it holds the generator's reset for a set number of cycles of the incoming board clock. Then it lets the generator run. The logic on the generated clock stays in reset until three things are true: the generator reports lock, the board reset button is up, and a further run of generated-clock cycles has passed.

Each delay is a shift register that fills with ones in its own clock domain. The lock flag and the button are each resynchronised into the generated-clock domain before they gate the second delay. A lost lock or a button press asserts the system reset at once, without waiting for a clock edge. Release is always synchronous, and it always waits for the full delay to run again from zero.

Top module: `clkgen_rst_seq`

## Requirements
- R1: After power-up, `pll_rst` is 1 and falls on the PLL_HOLD-th rising edge of `ext_clk` (default 16).
- R2: Once `pll_rst` has fallen it stays 0, whatever `pll_locked` and `ext_btn` do.
- R3: `sys_rst` is 1 at power-up and for as long as `pll_locked` is 0.
- R4: While `pll_locked` is 0 or `ext_btn` is 1 (1 means pressed), `sys_rst` is 1. It rises at once on such a fault, before any `sys_clk` edge.
- R5: `pll_locked` = 1 and `ext_btn` = 0 must both hold, measured from the later of the two. Then `sys_rst` falls on the (SYNC_STAGES + SYS_HOLD)-th rising edge of `sys_clk` (default 2 + 16 = 18), and not before.
- R6: A fault during the release count sets `sys_rst` to 1 and restarts the count from zero. This includes a fault one edge before release. After the fault clears, a full R5 count is needed again.
- R7: `sys_rst` never pulses high for a single `sys_clk` cycle. Once raised, it stays high for at least two sampled edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ext_clk | input | 1 | Board clock feeding the generator |
| ext_btn | input | 1 | Board reset button, 1 = pressed |
| sys_clk | input | 1 | Generated system clock |
| pll_locked | input | 1 | Lock flag from the generator, 1 = locked |
| pll_rst | output | 1 | Active-high reset to the generator, `ext_clk` domain |
| sys_rst | output | 1 | Active-high reset to system logic, `sys_clk` domain |

## Verification
Two events can land in the same `sys_clk` cycle: a new fault (lock loss or button press) and the edge that would end the release count. The bench provokes this directly by applying a fault half a cycle before the releasing edge. It also drops the button and raises lock in the same half-cycle, so the count must start from that common point. Random segments of faults and good stretches of random length are then judged against a bench-side edge counter that predicts `sys_rst` edge by edge.

// File: rtl/clkgen_rst_seq_pkg.sv
package clkgen_rst_seq_pkg;
  localparam int unsigned DEF_PLL_HOLD = 16;
  localparam int unsigned DEF_SYS_HOLD = 16;
  localparam int unsigned DEF_SYNC     = 2;

  // Edges of sys_clk from "conditions good" to release of the system reset.
  function automatic int unsigned release_latency(int unsigned sync_n, int unsigned hold_n);
    return sync_n + hold_n;
  endfunction
endpackage

// File: rtl/clkgen_rst_sync.sv
module clkgen_rst_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          INIT   = 1'b0
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain = {STAGES{INIT}};

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) chain <= d;
    end else begin : g_many
      always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkgen_rst_delay.sv
module clkgen_rst_delay #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic clr_async,
  input  logic go,
  output logic done
);
  logic [LEN-1:0] fill = '0;

  generate
    if (LEN == 1) begin : g_single
      always_ff @(posedge clk or posedge clr_async) begin
        if (clr_async)   fill <= '0;
        else             fill <= go;
      end
    end else begin : g_shift
      always_ff @(posedge clk or posedge clr_async) begin
        if (clr_async)   fill <= '0;
        else if (!go)    fill <= '0;
        else             fill <= {fill[LEN-2:0], 1'b1};
      end
    end
  endgenerate

  assign done = fill[LEN-1];
endmodule

// File: rtl/clkgen_rst_seq.sv
module clkgen_rst_seq
  import clkgen_rst_seq_pkg::*;
#(
  parameter int unsigned PLL_HOLD    = DEF_PLL_HOLD,
  parameter int unsigned SYS_HOLD    = DEF_SYS_HOLD,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic ext_clk,
  input  logic ext_btn,
  input  logic sys_clk,
  input  logic pll_locked,
  output logic pll_rst,
  output logic sys_rst
);
  logic pll_done;
  logic lock_s, btn_s, fault_raw, ok_s, sys_done;

  // Stage 1: power-up hold of the generator reset, external clock domain.
  clkgen_rst_delay #(.LEN(PLL_HOLD)) u_pll_delay (
    .clk(ext_clk), .clr_async(1'b0), .go(1'b1), .done(pll_done)
  );
  assign pll_rst = ~pll_done;

  // Stage 2: inputs brought into the generated-clock domain.
  clkgen_rst_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_lock_sync (
    .clk(sys_clk), .d(pll_locked), .q(lock_s)
  );
  clkgen_rst_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_btn_sync (
    .clk(sys_clk), .d(ext_btn), .q(btn_s)
  );

  assign fault_raw = ~pll_locked | ext_btn;
  assign ok_s      = lock_s & ~btn_s;

  clkgen_rst_delay #(.LEN(SYS_HOLD)) u_sys_delay (
    .clk(sys_clk), .clr_async(fault_raw), .go(ok_s), .done(sys_done)
  );
  assign sys_rst = ~sys_done;
endmodule

// File: rtl/clkgen_rst_seq_chk.sv
module clkgen_rst_seq_chk #(
  parameter int unsigned PLL_HOLD = 16
) (
  input logic ext_clk,
  input logic ext_btn,
  input logic sys_clk,
  input logic pll_locked,
  input logic pll_rst,
  input logic sys_rst
);
  logic ext_seen = 1'b0;
  logic sys_seen = 1'b0;
  logic sys_seen2 = 1'b0;
  int unsigned ext_cnt = 0;

  always_ff @(posedge ext_clk) begin
    ext_seen <= 1'b1;
    if (ext_cnt < PLL_HOLD + 4) ext_cnt <= ext_cnt + 1;
  end
  always_ff @(posedge sys_clk) begin
    sys_seen  <= 1'b1;
    sys_seen2 <= sys_seen;
  end

  // R1
  pll_hold_len_chk: assert property (@(posedge ext_clk) disable iff (!ext_seen)
    $fell(pll_rst) |-> ext_cnt == PLL_HOLD);
  // R2
  pll_stays_low_chk: assert property (@(posedge ext_clk) disable iff (!ext_seen)
    !pll_rst |=> !pll_rst);
  // R4
  sys_fault_hold_chk: assert property (@(posedge sys_clk) disable iff (!sys_seen)
    (!pll_locked || ext_btn) |-> sys_rst);
  // R5
  sys_release_cond_chk: assert property (@(posedge sys_clk) disable iff (!sys_seen2)
    !sys_rst |-> ($past(pll_locked) && !$past(ext_btn)));
  // R7
  sys_no_pulse_chk: assert property (@(posedge sys_clk) disable iff (!sys_seen2)
    $rose(sys_rst) |=> sys_rst);
endmodule

bind clkgen_rst_seq clkgen_rst_seq_chk #(.PLL_HOLD(PLL_HOLD)) u_chk (
  .ext_clk(ext_clk), .ext_btn(ext_btn), .sys_clk(sys_clk),
  .pll_locked(pll_locked), .pll_rst(pll_rst), .sys_rst(sys_rst)
);

// File: tb/test_clkgen_rst_seq.sv
module test_clkgen_rst_seq;
  localparam int unsigned PLL_HOLD = 16;
  localparam int unsigned SYS_HOLD = 16;
  localparam int unsigned SYNC     = 2;
  localparam int unsigned LAT      = SYNC + SYS_HOLD;

  logic ext_clk = 1'b0, sys_clk = 1'b0;
  logic ext_btn = 1'b0, pll_locked = 1'b0;
  logic pll_rst, sys_rst;
  int compared = 0, mismatched = 0;
  int unsigned cnt = 0;
  bit done = 1'b0;

  always #5 ext_clk = ~ext_clk;   // 100 MHz
  always #7 sys_clk = ~sys_clk;

  clkgen_rst_seq #(.PLL_HOLD(PLL_HOLD), .SYS_HOLD(SYS_HOLD), .SYNC_STAGES(SYNC)) i_clkgen_rst_seq (
    .ext_clk(ext_clk), .ext_btn(ext_btn), .sys_clk(sys_clk),
    .pll_locked(pll_locked), .pll_rst(pll_rst), .sys_rst(sys_rst)
  );

  function automatic bit exp_sys(int unsigned n);
    return !(n >= LAT);
  endfunction

  task automatic chk(input logic got, input logic exp, input string req);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // Inputs are set at a sys negedge; cnt counts good sys edges since then.
  task automatic set_in(input logic lk, input logic bt);
    pll_locked = lk;
    ext_btn    = bt;
    if (!lk || bt) cnt = 0;
  endtask

  task automatic step(input string req);
    @(posedge sys_clk);
    if (pll_locked && !ext_btn && cnt < 1000) cnt++;
    @(negedge sys_clk);
    chk(sys_rst, exp_sys(cnt), req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk(pll_rst, 1'b1, "R1");
    chk(sys_rst, 1'b1, "R3");
    for (int i = 1; i <= PLL_HOLD; i++) begin
      @(posedge ext_clk); @(negedge ext_clk);
      chk(pll_rst, (i < PLL_HOLD), "R1");
    end
    @(negedge sys_clk);
    set_in(1'b0, 1'b0);
    for (int i = 0; i < 30; i++) step("R3");
    // plain release
    set_in(1'b1, 1'b0);
    for (int i = 0; i < LAT + 4; i++) step("R5");
    // immediate assertion on lock loss
    pll_locked = 1'b0; cnt = 0; #1;
    chk(sys_rst, 1'b1, "R4");
    @(negedge sys_clk);
    for (int i = 0; i < 4; i++) step("R4");
    // partial count then button fault
    set_in(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) step("R6");
    ext_btn = 1'b1; cnt = 0; #1;
    chk(sys_rst, 1'b1, "R4");
    @(negedge sys_clk);
    for (int i = 0; i < 5; i++) step("R6");
    set_in(1'b1, 1'b0);
    for (int i = 0; i < LAT + 2; i++) step("R6");
    // fault one edge before release, lock rise and button drop together
    set_in(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step("R4");
    set_in(1'b1, 1'b0);
    for (int i = 0; i < LAT - 1; i++) step("R5");
    set_in(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) step("R6");
    set_in(1'b1, 1'b0);
    for (int i = 0; i < LAT + 2; i++) step("R6");
    // random segments
    for (int s = 0; s < 40; s++) begin
      int unsigned kind = $urandom_range(0, 2);
      set_in(kind == 1, kind != 1);
      if (kind == 2) set_in(1'b0, 1'b1);
      for (int i = 0; i < int'($urandom_range(3, 8)); i++) step("R4");
      set_in(1'b1, 1'b0);
      for (int i = 0; i < int'($urandom_range(0, LAT + 6)); i++) step("R5");
      chk(pll_rst, 1'b0, "R2");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin #2000000; mismatched++; $display("FAIL watchdog: got timeout expected finish"); end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule